// File: doc/BRIEF.md
# Pad Boundary Scan Register

This block is the boundary scan data register for a row of bidirectional digital pads. A separate TAP controller supplies decoded strobes for capture, shift and update, plus one-hot instruction selects for sample/preload, external test and internal test. Each pad owns three serial cells: the value arriving at the pad, the value the core wants to drive, and the core's drive enable. The block snapshots these live values into the cells and moves them serially from `tdi` to `tdo`. It then transfers the shifted-in pattern into a bank of update latches.

Those latches matter only under a test instruction. Under external test, the latched output and enable bits drive the pads in place of the core. Under internal test, the latched input bits reach the core in place of the pad values. With no test instruction active, the pad and core connections pass straight through and the chain is invisible to functional logic.

Top module: `pad_bscan_reg`

## Requirements
- R1: The chain holds 3*NUM_PADS cells. Cell index 3*p+0 holds pad p's input value, 3*p+1 its output value and 3*p+2 its enable value. Index 0 (pad 0 input) is nearest `tdi`, and index 3*NUM_PADS-1 (last pad enable) is nearest `tdo`.
- R2: On a rising `tck` edge with `capture_dr` high and any instruction select high, each pad's cells load `pad_in`, `core_out` and `core_oe`.
- R3: On a rising `tck` edge with `shift_dr` high and a select high, every cell takes its neighbour's value toward `tdo`, and cell 0 takes `tdi`. If `capture_dr` is also high, the shift wins and the capture is ignored.
- R4: `tdo` shows the last cell of the chain and changes only on the falling edge of `tck`.
- R5: The update latches load the whole chain on a falling `tck` edge with `update_dr` and a select high. At all other times they hold, including while the chain shifts.
- R6: With `sel_extest` high, `pad_out[p]` equals latch 3*p+1 and `pad_oe[p]` equals latch 3*p+2.
- R7: With `sel_intest` high, `core_in[p]` equals latch 3*p+0.
- R8: With `sel_extest` low, `pad_out`/`pad_oe` equal `core_out`/`core_oe`. With `sel_intest` low, `core_in` equals `pad_in`, whatever the chain or latches hold.
- R9: `trst_n` low clears the cells on the next rising edge, and clears the latches and `tdo` on the next falling edge.
- R10: With no instruction select high, the capture, shift and update strobes change neither the cells nor the latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Synchronous test reset, active low |
| capture_dr | input | 1 | Capture strobe from the TAP state decode |
| shift_dr | input | 1 | Shift strobe from the TAP state decode |
| update_dr | input | 1 | Update strobe from the TAP state decode |
| sel_sample | input | 1 | Sample/preload instruction selected |
| sel_extest | input | 1 | External test instruction selected |
| sel_intest | input | 1 | Internal test instruction selected |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, falling-edge timed |
| pad_in | input | NUM_PADS | Values seen at the pads |
| core_out | input | NUM_PADS | Core output data per pad |
| core_oe | input | NUM_PADS | Core output enable per pad |
| pad_out | output | NUM_PADS | Data to the pad drivers |
| pad_oe | output | NUM_PADS | Enable to the pad drivers |
| core_in | output | NUM_PADS | Pad input values delivered to the core |

## Verification
Capture and shift can be requested on the same rising edge. The bench raises `capture_dr` and `shift_dr` together for one edge, with the live pad values differing from the chain contents, then reads the whole chain out. It passes only if the stream shows the shifted `tdi` bit and the old contents moved by one place, with no captured values. Shifting and holding the latched pattern also overlap: under external test, a complete new pattern is shifted in while the bench confirms that the pad drivers keep the old latched values until the update strobe.

// File: rtl/pad_bscan_pkg.sv
package pad_bscan_pkg;
  localparam int CELLS_PER_PAD = 3;

  // Field order inside the packed struct follows the chain direction:
  // din is nearest tdi, oe is nearest tdo.
  typedef struct packed {
    logic oe;
    logic dout;
    logic din;
  } pad_cells_t;
endpackage

// File: rtl/pbs_group.sv
module pbs_group
  import pad_bscan_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       cap_en,
  input  logic       shf_en,
  input  logic       upd_en,
  input  logic       ser_in,
  input  logic       smp_in,
  input  logic       smp_out,
  input  logic       smp_oe,
  output logic       ser_out,
  output pad_cells_t held
);
  pad_cells_t stage;

  // serial stage: shift takes precedence over capture
  always_ff @(posedge tck) begin
    if (!trst_n) begin
      stage <= '0;
    end else if (shf_en) begin
      stage.din  <= ser_in;
      stage.dout <= stage.din;
      stage.oe   <= stage.dout;
    end else if (cap_en) begin
      stage.din  <= smp_in;
      stage.dout <= smp_out;
      stage.oe   <= smp_oe;
    end
  end

  // update latches move on the falling edge only
  always_ff @(negedge tck) begin
    if (!trst_n) held <= '0;
    else if (upd_en) held <= stage;
  end

  assign ser_out = stage.oe;

  a_r2_capture_loads: assert property (@(posedge tck) disable iff (!trst_n)
    (cap_en && !shf_en) |=> (stage.din == $past(smp_in) &&
                             stage.dout == $past(smp_out) &&
                             stage.oe == $past(smp_oe)));

  a_r3_shift_moves: assert property (@(posedge tck) disable iff (!trst_n)
    shf_en |=> (stage.din == $past(ser_in) &&
                stage.dout == $past(stage.din) &&
                stage.oe == $past(stage.dout)));

  a_r5_latch_holds: assert property (@(negedge tck) disable iff (!trst_n)
    !upd_en |=> $stable(held));
endmodule

// File: rtl/pbs_padmux.sv
module pbs_padmux
  import pad_bscan_pkg::*;
(
  input  logic       ext_mode,
  input  logic       int_mode,
  input  pad_cells_t held,
  input  logic       core_out,
  input  logic       core_oe,
  input  logic       pad_in,
  output logic       pad_out,
  output logic       pad_oe,
  output logic       core_in
);
  assign pad_out = ext_mode ? held.dout : core_out;
  assign pad_oe  = ext_mode ? held.oe   : core_oe;
  assign core_in = int_mode ? held.din  : pad_in;
endmodule

// File: rtl/pbs_tdo.sv
module pbs_tdo (
  input  logic tck,
  input  logic trst_n,
  input  logic last_cell,
  output logic tdo
);
  always_ff @(negedge tck) begin
    if (!trst_n) tdo <= 1'b0;
    else tdo <= last_cell;
  end

  a_r4_tdo_falling: assert property (@(negedge tck) disable iff (!trst_n)
    tdo == $past(last_cell));
endmodule

// File: rtl/pad_bscan_reg.sv
module pad_bscan_reg
  import pad_bscan_pkg::*;
#(
  parameter int NUM_PADS = 4
) (
  input  logic                tck,
  input  logic                trst_n,
  input  logic                capture_dr,
  input  logic                shift_dr,
  input  logic                update_dr,
  input  logic                sel_sample,
  input  logic                sel_extest,
  input  logic                sel_intest,
  input  logic                tdi,
  output logic                tdo,
  input  logic [NUM_PADS-1:0] pad_in,
  input  logic [NUM_PADS-1:0] core_out,
  input  logic [NUM_PADS-1:0] core_oe,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  output logic [NUM_PADS-1:0] core_in
);
  localparam int CHAIN_LEN = CELLS_PER_PAD * NUM_PADS;

  logic chain_sel;
  logic cap_en, shf_en, upd_en;
  logic [NUM_PADS-1:0] link;
  pad_cells_t held [NUM_PADS];

  assign chain_sel = sel_sample | sel_extest | sel_intest;
  assign cap_en    = capture_dr & chain_sel;
  assign shf_en    = shift_dr   & chain_sel;
  assign upd_en    = update_dr  & chain_sel;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    logic ser_in;
    if (p == 0) begin : g_head
      assign ser_in = tdi;
    end else begin : g_body
      assign ser_in = link[p-1];
    end

    pbs_group u_group (
      .tck     (tck),
      .trst_n  (trst_n),
      .cap_en  (cap_en),
      .shf_en  (shf_en),
      .upd_en  (upd_en),
      .ser_in  (ser_in),
      .smp_in  (pad_in[p]),
      .smp_out (core_out[p]),
      .smp_oe  (core_oe[p]),
      .ser_out (link[p]),
      .held    (held[p])
    );

    pbs_padmux u_mux (
      .ext_mode (sel_extest),
      .int_mode (sel_intest),
      .held     (held[p]),
      .core_out (core_out[p]),
      .core_oe  (core_oe[p]),
      .pad_in   (pad_in[p]),
      .pad_out  (pad_out[p]),
      .pad_oe   (pad_oe[p]),
      .core_in  (core_in[p])
    );
  end

  pbs_tdo u_tdo (
    .tck       (tck),
    .trst_n    (trst_n),
    .last_cell (link[NUM_PADS-1]),
    .tdo       (tdo)
  );

  a_r8_pads_transparent: assert property (@(negedge tck) disable iff (!trst_n)
    !sel_extest |-> (pad_out == core_out && pad_oe == core_oe));

  a_r8_core_transparent: assert property (@(negedge tck) disable iff (!trst_n)
    !sel_intest |-> (core_in == pad_in));

  initial begin
    a_r1_chain_len: assert (CHAIN_LEN == 3 * NUM_PADS && NUM_PADS > 0);
  end
endmodule

// File: tb/pad_bscan_reg_bench.sv
module pad_bscan_reg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int L  = 3 * NP;

  logic tck = 1'b0, trst_n = 1'b0;
  logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
  logic sel_sample = 1'b0, sel_extest = 1'b0, sel_intest = 1'b0, tdi = 1'b0;
  logic [NP-1:0] pad_in = '0, core_out = '0, core_oe = '0;
  logic [NP-1:0] pad_out, pad_oe, core_in;
  logic tdo;

  int n_chk = 0, n_fail = 0;
  logic [L-1:0] m_sr = '0, m_upd = '0;
  logic exp_q[$];

  pad_bscan_reg #(.NUM_PADS(NP)) u_pad_bscan_reg (
    .tck(tck), .trst_n(trst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .sel_sample(sel_sample), .sel_extest(sel_extest),
    .sel_intest(sel_intest), .tdi(tdi), .tdo(tdo), .pad_in(pad_in),
    .core_out(core_out), .core_oe(core_oe), .pad_out(pad_out),
    .pad_oe(pad_oe), .core_in(core_in)
  );

  always #(CLK_PERIOD/2) tck = ~tck;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected serial bit per selected shift edge
  always @(posedge tck) begin
    if (shift_dr && (sel_sample || sel_extest || sel_intest)) begin
      if (exp_q.size() == 0) check("R3 scoreboard underrun", 32'd1, 32'd0);
      else check("R1/R3/R4 tdo bit", {31'b0, tdo}, {31'b0, exp_q.pop_front()});
    end
  end

  task automatic tick();
    @(posedge tck);
    #2;
  endtask

  function automatic logic [L-1:0] live();
    logic [L-1:0] v;
    for (int p = 0; p < NP; p++) begin
      v[3*p]   = pad_in[p];
      v[3*p+1] = core_out[p];
      v[3*p+2] = core_oe[p];
    end
    return v;
  endfunction

  function automatic logic [NP-1:0] pick(input logic [L-1:0] v, input int c);
    logic [NP-1:0] r;
    for (int p = 0; p < NP; p++) r[p] = v[3*p+c];
    return r;
  endfunction

  task automatic do_capture();
    capture_dr = 1'b1;
    m_sr = live();
    tick();
    capture_dr = 1'b0;
  endtask

  task automatic do_shift(input logic [L-1:0] pat);
    shift_dr = 1'b1;
    for (int i = 0; i < L; i++) begin
      tdi = pat[L-1-i];
      exp_q.push_back(m_sr[L-1]);
      m_sr = {m_sr[L-2:0], tdi};
      tick();
    end
    shift_dr = 1'b0;
  endtask

  task automatic do_update();
    update_dr = 1'b1;
    m_upd = m_sr;
    tick();
    update_dr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    check("watchdog expired", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    core_out = 4'b1010; core_oe = 4'b0110; pad_in = 4'b0011;
    repeat (3) tick();
    check("R9 tdo in reset", {31'b0, tdo}, 32'd0);
    check("R8 pad_out in reset", {28'b0, pad_out}, {28'b0, core_out});
    trst_n = 1'b1;
    tick();

    // sample, then preload a pattern while reading the snapshot
    sel_sample = 1'b1;
    do_capture();
    do_shift(12'hA5C);
    check("R8 pad_out before update", {28'b0, pad_out}, {28'b0, core_out});
    do_update();
    check("R8 pad_oe after update, no test", {28'b0, pad_oe}, {28'b0, core_oe});
    check("R8 core_in after update, no test", {28'b0, core_in}, {28'b0, pad_in});

    // external test drives the pads from the latches
    sel_sample = 1'b0; sel_extest = 1'b1;
    #1;
    check("R6 pad_out from latch", {28'b0, pad_out}, {28'b0, pick(m_upd, 1)});
    check("R6 pad_oe from latch", {28'b0, pad_oe}, {28'b0, pick(m_upd, 2)});
    check("R8 core_in under extest", {28'b0, core_in}, {28'b0, pad_in});

    // new live values; shifting must not disturb the driven pads
    pad_in = 4'b1100; core_out = 4'b0101; core_oe = 4'b1001;
    do_capture();
    do_shift(12'h3C6);
    check("R5 pad_out held while shifting", {28'b0, pad_out}, {28'b0, pick(m_upd, 1)});
    check("R5 pad_oe held while shifting", {28'b0, pad_oe}, {28'b0, pick(m_upd, 2)});
    do_update();
    check("R6 pad_out new latch", {28'b0, pad_out}, {28'b0, pick(m_upd, 1)});
    check("R6 pad_oe new latch", {28'b0, pad_oe}, {28'b0, pick(m_upd, 2)});

    // internal test feeds the core from the latches
    sel_extest = 1'b0; sel_intest = 1'b1;
    #1;
    check("R7 core_in from latch", {28'b0, core_in}, {28'b0, pick(m_upd, 0)});
    check("R8 pad_out under intest", {28'b0, pad_out}, {28'b0, core_out});

    // capture and shift on the same edge: shift wins (R3)
    pad_in = 4'b0000; core_out = 4'b1111; core_oe = 4'b1111;
    capture_dr = 1'b1; shift_dr = 1'b1; tdi = 1'b1;
    exp_q.push_back(m_sr[L-1]);
    m_sr = {m_sr[L-2:0], 1'b1};
    tick();
    capture_dr = 1'b0; shift_dr = 1'b0;
    do_shift(12'h5A3);

    // no instruction selected: strobes ignored (R10)
    sel_intest = 1'b0;
    capture_dr = 1'b1; tick(); capture_dr = 1'b0;
    shift_dr = 1'b1; tdi = 1'b0; tick(); tick(); shift_dr = 1'b0;
    update_dr = 1'b1; tick(); update_dr = 1'b0;
    sel_extest = 1'b1;
    #1;
    check("R10 latch unchanged (pad_out)", {28'b0, pad_out}, {28'b0, pick(m_upd, 1)});
    check("R10 latch unchanged (pad_oe)", {28'b0, pad_oe}, {28'b0, pick(m_upd, 2)});
    do_shift(12'h000);

    // reset clears latches and tdo (R9)
    trst_n = 1'b0;
    tick(); tick();
    check("R9 pad_out cleared", {28'b0, pad_out}, 32'd0);
    check("R9 pad_oe cleared", {28'b0, pad_oe}, 32'd0);
    check("R9 tdo cleared", {31'b0, tdo}, 32'd0);
    trst_n = 1'b1;
    tick();

    if (exp_q.size() != 0) check("R3 scoreboard leftover", exp_q.size(), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule